// File: doc/BRIEF.md
# Timer clock select and prescaler

This block decides, cycle by cycle, whether a timer/counter advances. It returns a count-enable strobe that is synchronous to the I/O clock. A 3-bit select code picks one of eight sources:

- stopped;
- every I/O clock cycle;
- the I/O clock divided by 8, 64, 256 or 1024;
- a falling or a rising edge on an external clock pin.

The counter it drives sits outside this block. So does any other consumer of the strobe.

The divided rates all come from one free-running prescaler counter. It steps on every I/O clock cycle and is not restarted when the select code changes. The external pin passes through a two-flop synchronizer before the edge detector. The pin's level is sampled whatever its direction, so the pin can also be driven by the same chip.

Top module: `tmr_clk_sel`

## Requirements
- R1: With select code 3'b000 the strobe stays low.
- R2: With select code 3'b001 the strobe is high in every cycle out of reset.
- R3: Codes 3'b010, 3'b011, 3'b100 and 3'b101 give one strobe per 8, 64, 256 and 1024 cycles. After c I/O clock edges since reset release, the strobe is high exactly when c mod N equals N-1.
- R4: The prescaler keeps running across select changes. A divided mode chosen mid-run follows the count since reset release, not since the change.
- R5: With code 3'b110, a high-then-low change of the pin seen at two successive clock edges k-1 and k makes the strobe high in the cycle that follows edge k+1.
- R6: With code 3'b111, a low-then-high change seen at edges k-1 and k makes the strobe high in the cycle that follows edge k+1.
- R7: Each synchronized pin edge gives exactly one strobe. A pin pulse held for a single clock period still yields one strobe.
- R8: While reset is asserted the strobe is low for every code. Reset clears the prescaler and the synchronizer to zero.
- R9: In every mode other than 3'b001, the strobe is never high in two consecutive cycles while the select code stays the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_io | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 3 | Clock source select code |
| ext_pin | input | 1 | External clock pin level, asynchronous |
| cnt_en | output | 1 | One-cycle count-enable strobe |

## Verification
Random runs hold each select code for stretches of varying length. During these stretches the pin does one of three things:

- toggles rarely, which separates the falling-edge mode from the rising-edge mode;
- changes on every cycle, which tests the one-strobe-per-edge rule;
- gives single-cycle pulses, which exercises the synchronizer latency.

Directed parts switch from the slowest division to the fastest in mid-run and reset the block in mid-run. These show that the prescaler is neither restarted by a select change nor left stale by a reset.

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel #(
  parameter int PRE_W = 10,
  parameter int TAP_A = 3,
  parameter int TAP_B = 6,
  parameter int TAP_C = 8
) (
  input  logic       clk_io,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       ext_pin,
  output logic       cnt_en
);

  localparam int SYNC_N = 3;

  logic [PRE_W-1:0]  pre;
  logic [SYNC_N-1:0] xs;
  logic              en_sel;

  always_ff @(posedge clk_io or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      xs  <= '0;
    end else begin
      pre <= pre + PRE_W'(1);
      xs  <= {xs[SYNC_N-2:0], ext_pin};
    end
  end

  wire tap_a = &pre[TAP_A-1:0];
  wire tap_b = &pre[TAP_B-1:0];
  wire tap_c = &pre[TAP_C-1:0];
  wire tap_d = &pre;
  wire rise  = xs[SYNC_N-2] & ~xs[SYNC_N-1];
  wire fall  = ~xs[SYNC_N-2] & xs[SYNC_N-1];

  always_comb begin
    case (sel)
      3'd0:    en_sel = 1'b0;
      3'd1:    en_sel = 1'b1;
      3'd2:    en_sel = tap_a;
      3'd3:    en_sel = tap_b;
      3'd4:    en_sel = tap_c;
      3'd5:    en_sel = tap_d;
      3'd6:    en_sel = fall;
      default: en_sel = rise;
    endcase
  end

  assign cnt_en = rst_n & en_sel;

  p_stop_r1: assert property (@(posedge clk_io) disable iff (!rst_n)
    (sel == 3'd0) |-> !cnt_en);

  p_every_r2: assert property (@(posedge clk_io) disable iff (!rst_n)
    (sel == 3'd1) |-> cnt_en);

  p_div8_phase_r3: assert property (@(posedge clk_io) disable iff (!rst_n)
    (sel == 3'd2 && cnt_en) |=> (pre[TAP_A-1:0] == '0));

  p_pre_step_r4: assert property (@(posedge clk_io) disable iff (!rst_n)
    $past(rst_n) |-> (pre == $past(pre) + PRE_W'(1)));

  p_single_r9: assert property (@(posedge clk_io) disable iff (!rst_n)
    (cnt_en && sel != 3'd1) |=> (!cnt_en || sel != $past(sel)));

endmodule

// File: tb/sim_tmr_clk_sel.sv
`timescale 1ns/1ps
module sim_tmr_clk_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       ext_pin = 1'b0;
  logic       cnt_en;

  int unsigned runs = 0, fails = 0;
  int unsigned c = 0;
  bit h0 = 0, h1 = 0, h2 = 0;
  bit prev_en = 0;
  logic [2:0] prev_sel = 3'd0;

  always #2 clk = ~clk;

  tmr_clk_sel u0 (.clk_io(clk), .rst_n(rst_n), .sel(sel), .ext_pin(ext_pin), .cnt_en(cnt_en));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c = 0; h0 = 0; h1 = 0; h2 = 0;
    end else begin
      c = c + 1; h2 = h1; h1 = h0; h0 = ext_pin;
    end
  end

  function automatic bit exp_en(input logic [2:0] s, input int unsigned n, input bit a1, input bit a2);
    case (s)
      3'd0: return 1'b0;
      3'd1: return 1'b1;
      3'd2: return (n % 8) == 7;
      3'd3: return (n % 64) == 63;
      3'd4: return (n % 256) == 255;
      3'd5: return (n % 1024) == 1023;
      3'd6: return !a1 && a2;
      default: return a1 && !a2;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] s);
    case (s)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd6: return "R5/R7";
      3'd7: return "R6/R7";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string tag, input bit act, input bit exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: cnt_en=%0b expected %0b (sel=%0d cycle=%0d)", tag, act, exp, sel, c);
    end
  endtask

  task automatic step(input logic [2:0] s, input bit p, input string tag);
    @(negedge clk);
    sel = s; ext_pin = p;
    #1;
    if (!rst_n) check("R8", cnt_en, 1'b0);
    else begin
      check(tag, cnt_en, exp_en(s, c, h1, h2));
      if (prev_en && s == prev_sel && s != 3'd1) check("R9", cnt_en, 1'b0);
    end
    prev_en = rst_n && cnt_en; prev_sel = s;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; ext_pin = 1'b0;
    for (int i = 0; i < 8; i++) step(3'(i), 1'b0, "R8");
    @(negedge clk); rst_n = 1'b1;
    #1 check("R8", cnt_en, 1'b0);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7731));
    do_reset();
    for (int i = 0; i < 1100; i++) step(3'd2, 1'b0, "R3");
    // R4: slowest divider for a while, then the fastest, no restart
    for (int i = 0; i < 333; i++) step(3'd5, 1'b0, "R3");
    for (int i = 0; i < 40; i++) step(3'd2, 1'b0, "R4");
    for (int i = 0; i < 900; i++) step(3'd5, 1'b0, "R4");
    // R7: single-cycle pulses on the pin
    for (int i = 0; i < 60; i++) step(3'd7, (i % 10) == 3, "R7");
    for (int i = 0; i < 60; i++) step(3'd6, (i % 10) != 3, "R7");
    for (int i = 0; i < 20; i++) step(3'd1, 1'b0, "R2");
    for (int i = 0; i < 20; i++) step(3'd0, 1'b1, "R1");
    // R8: reset mid-run clears the prescaler phase
    do_reset();
    for (int i = 0; i < 300; i++) step(3'd4, 1'b0, "R8");
    for (int seg = 0; seg < 36; seg++) begin
      logic [2:0] s = 3'($urandom_range(0, 7));
      int unsigned len = $urandom_range(20, 2500);
      int unsigned mode = $urandom_range(0, 2);
      bit p = ext_pin;
      for (int i = 0; i < int'(len); i++) begin
        case (mode)
          0: if ($urandom_range(0, 15) == 0) p = ~p;
          1: p = 1'($urandom);
          default: p = ($urandom_range(0, 6) == 0);
        endcase
        step(s, p, tag_of(s));
      end
    end
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule